// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

A watchdog timer that sits on a simple register bus and requests a system reset when software stops servicing it. Three 32-bit registers are exposed: a control word that holds a 2-bit reset-configuration field, a status word that records watchdog resets and keeps a few scratch bits, and a count word that holds a 20-bit countdown. No register changes unless the write carries the 8-bit key 0x5A in bits 31:24.

Software loads the countdown and then writes the configuration code for a full reset, which arms the timer. While armed, the count drops by one every `TICK_DIV` clock cycles. Software reloads the count to keep the system alive. Disarming is done by writing a configuration code other than the full-reset code. If the count reaches zero while armed, the block raises `reset_req` for `PULSE_LEN` cycles and sets the hard-reset flag. It also disarms itself and leaves the count at zero. Only `rst_n` (power-on reset) clears the status bits, so software can read them after the system restarts.

Top module: `wdog_keyed_reset`

## Requirements
- R1: After `rst_n` is released, all three registers read as zero and `reset_req` is low.
- R2: A write whose bits 31:24 differ from 0x5A changes no register.
- R3: A keyed write to offset 0x24 loads bits 19:0 into the count. A read of offset 0x24 returns the current count in bits 19:0 and zeros in the other bits.
- R4: A keyed write to offset 0x1C stores bits 5:4 as the configuration field. The value 2'b10 arms the watchdog. A read of 0x1C returns the field in bits 5:4, so bit 5 reads 1 while the watchdog is armed. All other bits read 0.
- R5: The count drops by one after every `TICK_DIV` armed cycles, and only while the watchdog is armed. While disarmed, it holds its value.
- R6: A keyed write to the count while armed reloads the count and restarts the tick phase, so a timely reload keeps `reset_req` low.
- R7: If the count is zero while armed and no count write happens in that cycle, `reset_req` goes high on the next cycle and stays high for exactly `PULSE_LEN` (16) cycles. In the same step, status bit 6 is set, the configuration field is cleared and the count stays at zero.
- R8: A keyed write of 0x102 to offset 0x1C disarms the watchdog, after which the count holds and no reset is requested.
- R9: A keyed write to offset 0x20 stores bits 0, 2, 4, 6, 8 and 10 (mask 0x555). All other status bits read 0. The stored bits and the hard-reset flag survive a watchdog reset and are cleared only by `rst_n`.
- R10: Reads of any other offset return zero, and `rdata` is zero whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; read data is combinational |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data; bits 31:24 carry the key |
| rdata | output | 32 | Read data |
| reset_req | output | 1 | System reset request pulse |

## Verification
The assertions assume that the bus has only one requester: writes are single-cycle strobes and the address is stable while `wr_en` is high. The stability properties also assume that `rst_n` is the only way the state can be cleared. The stimulus drives every access as a one-cycle strobe set up on the falling edge. It never asserts `wr_en` and `rd_en` in the same cycle. It makes keyed and unkeyed writes to each register, reloads the count just before expiry and a few cycles before it, and arms the watchdog with a count of zero. A behavioural model in the bench follows each clock and is compared with `reset_req` every cycle and with `rdata` on every read.

// File: rtl/wdog_keyed_reset.sv
module wdog_keyed_reset #(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 20,
  parameter int TICK_DIV  = 4,
  parameter int PULSE_LEN = 16,
  parameter logic [7:0] KEY = 8'h5A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        reset_req
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h1C);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'(8'h24);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PLS_W = $clog2(PULSE_LEN + 1);
  localparam logic [10:0] STAT_MASK = 11'h555;
  localparam logic [10:0] HARD_FLAG = 11'h040;
  localparam logic [1:0]  CFG_FULL  = 2'b10;

  logic [1:0]       cfg_q;
  logic [10:0]      stat_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PLS_W-1:0] pls_q;
  logic             unused_wdata;

  wire key_ok  = wdata[31:24] == KEY;
  wire wr_ctrl = wr_en && key_ok && addr == OFF_CTRL;
  wire wr_stat = wr_en && key_ok && addr == OFF_STAT;
  wire wr_cnt  = wr_en && key_ok && addr == OFF_CNT;
  wire armed   = cfg_q == CFG_FULL;
  wire tick    = pre_q == PRE_W'(TICK_DIV - 1);
  wire fire    = armed && cnt_q == '0 && !wr_cnt;

  assign unused_wdata = ^wdata;
  assign reset_req = pls_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata[CNT_W-1:0];
      pre_q <= '0;
    end else if (armed && cnt_q != '0) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end else begin
      pre_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (fire)    cfg_q <= '0;
    else if (wr_ctrl) cfg_q <= wdata[5:4];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (wr_stat ? (wdata[10:0] & STAT_MASK) : stat_q)
                          | (fire ? HARD_FLAG : 11'h000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pls_q <= '0;
    else if (fire)         pls_q <= PLS_W'(PULSE_LEN);
    else if (pls_q != '0)  pls_q <= pls_q - 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_CTRL: rdata[5:4]       = cfg_q;
        OFF_STAT: rdata[10:0]      = stat_q;
        OFF_CNT:  rdata[CNT_W-1:0] = cnt_q;
        default:  rdata            = '0;
      endcase
    end
  end
endmodule

module wdog_keyed_reset_chk #(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 20,
  parameter int PULSE_LEN = 16,
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              reset_req,
  input logic [1:0]        cfg,
  input logic [10:0]       stat,
  input logic [CNT_W-1:0]  cnt
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2);
  logic [RUN_W-1:0] run_len;
  wire armed  = cfg == 2'b10;
  wire bad_wr = wr_en && wdata[31:24] != KEY;
  wire cnt_wr = wr_en && wdata[31:24] == KEY && addr == ADDR_W'(8'h24);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_len <= '0;
    else if (reset_req) begin
      if (run_len != '1) run_len <= run_len + 1'b1;
    end else                     run_len <= '0;
  end

  assert_pulse_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RUN_W'(PULSE_LEN));
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && run_len != '0) |-> run_len == RUN_W'(PULSE_LEN));
  assert_fire_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> (stat[6] && cfg == 2'b00 && cnt == '0));
  assert_hold_disarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !cnt_wr) |=> $stable(cnt));
  assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_wr && !armed) |=> ($stable(cnt) && $stable(cfg) && $stable(stat)));
  assert_scratch_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~11'h555) == 11'h000);
endmodule

bind wdog_keyed_reset wdog_keyed_reset_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .reset_req(reset_req), .cfg(cfg_q), .stat(stat_q), .cnt(cnt_q)
);

// File: tb/wdog_keyed_reset_test.sv
module wdog_keyed_reset_test;
  localparam int DIV = 4;
  localparam int PLS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        reset_req;

  int vectors = 0;
  int misses = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural model state
  int m_cfg = 0, m_stat = 0, m_cnt = 0, m_pre = 0, m_pls = 0;

  wdog_keyed_reset #(.TICK_DIV(DIV), .PULSE_LEN(PLS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .reset_req(reset_req)
  );

  always #5 clk = ~clk;

  function automatic int model_read(input logic [7:0] a);
    case (a)
      8'h1C: return m_cfg << 4;
      8'h20: return m_stat;
      8'h24: return m_cnt;
      default: return 0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h1C: return "R4";
      8'h20: return "R9";
      8'h24: return "R3";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    bit key, wc, ws, wn, armed, fire;
    int n_cfg, n_stat, n_cnt, n_pre, n_pls;
    cycles++;
    if (!rst_n) begin
      m_cfg = 0; m_stat = 0; m_cnt = 0; m_pre = 0; m_pls = 0;
    end else begin
      key = wdata[31:24] == 8'h5A;
      wc = wr_en && key && addr == 8'h1C;
      ws = wr_en && key && addr == 8'h20;
      wn = wr_en && key && addr == 8'h24;
      armed = m_cfg == 2;
      fire = armed && m_cnt == 0 && !wn;
      n_cfg = m_cfg; n_stat = m_stat; n_cnt = m_cnt; n_pre = m_pre; n_pls = m_pls;
      if (wn) begin
        n_cnt = int'(wdata[19:0]); n_pre = 0;
      end else if (armed && m_cnt != 0) begin
        if (m_pre == DIV - 1) begin n_pre = 0; n_cnt = m_cnt - 1; end
        else n_pre = m_pre + 1;
      end else n_pre = 0;
      if (fire) n_cfg = 0;
      else if (wc) n_cfg = int'(wdata[5:4]);
      if (ws) n_stat = int'(wdata[10:0]) & 'h555;
      if (fire) n_stat = n_stat | 'h40;
      if (fire) n_pls = PLS;
      else if (m_pls != 0) n_pls = m_pls - 1;
      m_cfg = n_cfg; m_stat = n_stat; m_cnt = n_cnt; m_pre = n_pre; m_pls = n_pls;
    end
    #2;
    vectors++;
    if (reset_req !== (m_pls != 0)) begin
      misses++;
      $display("FAIL R7 (%s) reset_req actual=%0b expected=%0b at cycle %0d",
               tag, reset_req, m_pls != 0, cycles);
    end
    vectors++;
    if (rdata !== (rd_en ? 32'(model_read(addr)) : 32'h0)) begin
      misses++;
      $display("FAIL %s (%s) rdata@%h actual=%h expected=%h", read_tag(addr), tag,
               addr, rdata, rd_en ? 32'(model_read(addr)) : 32'h0);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = 32'h0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1;
    vectors++;
    if (rdata !== exp) begin
      misses++;
      $display("FAIL %s read@%h actual=%h expected=%h", r, a, rdata, exp);
    end
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    expect_rd(8'h1C, 32'h0, "R1");
    expect_rd(8'h20, 32'h0, "R1");
    expect_rd(8'h24, 32'h0, "R1");

    tag = "R2";
    bus_wr(8'h24, 32'h5B012345);
    expect_rd(8'h24, 32'h0, "R2");
    bus_wr(8'h1C, 32'h00000020);
    expect_rd(8'h1C, 32'h0, "R2");
    bus_wr(8'h20, 32'hA5000555);
    expect_rd(8'h20, 32'h0, "R2");

    tag = "R3";
    bus_wr(8'h24, 32'h5AFABCDE);
    expect_rd(8'h24, 32'h000ABCDE, "R3");
    tag = "R5";
    idle(12);
    expect_rd(8'h24, 32'h000ABCDE, "R5");

    tag = "R4";
    bus_wr(8'h24, 32'h5A000100);
    bus_wr(8'h1C, 32'h5A0000F0 & 32'hFFFFFFEF);
    expect_rd(8'h1C, 32'h00000020, "R4");
    tag = "R5";
    idle(20);
    bus_wr(8'h1C, 32'h5A000102);
    tag = "R8";
    expect_rd(8'h1C, 32'h0, "R8");
    expect_rd(8'h24, 32'(model_read(8'h24)), "R8");
    idle(30);
    expect_rd(8'h24, 32'(model_read(8'h24)), "R8");

    tag = "R9";
    bus_wr(8'h20, 32'h5A000FFF);
    expect_rd(8'h20, 32'h00000555, "R9");
    bus_wr(8'h20, 32'h5A000515);
    expect_rd(8'h20, 32'h00000515, "R9");

    tag = "R6";
    bus_wr(8'h24, 32'h5A00000A);
    bus_wr(8'h1C, 32'h5A000020);
    for (int i = 0; i < 5; i++) begin
      idle(30);
      bus_wr(8'h24, 32'h5A00000A);
    end
    idle(38);
    bus_wr(8'h24, 32'h5A00000A);

    tag = "R7";
    idle(70);
    expect_rd(8'h20, 32'h00000555, "R7");
    expect_rd(8'h1C, 32'h0, "R7");
    expect_rd(8'h24, 32'h0, "R7");
    tag = "R9";
    idle(20);
    expect_rd(8'h20, 32'h00000555, "R9");

    tag = "R7";
    bus_wr(8'h20, 32'h5A000001);
    bus_wr(8'h1C, 32'h5A000020);
    idle(25);
    expect_rd(8'h20, 32'h00000041, "R7");

    tag = "R10";
    expect_rd(8'h28, 32'h0, "R10");
    expect_rd(8'h00, 32'h0, "R10");
    @(negedge clk); addr = 8'h20; rd_en = 1'b0;
    #1;
    vectors++;
    if (rdata !== 32'h0) begin
      misses++;
      $display("FAIL R10 idle rdata actual=%h expected=%h", rdata, 32'h0);
    end

    tag = "R1";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    expect_rd(8'h20, 32'h0, "R1");
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #1000000;
    misses++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule